// File: doc/BRIEF.md
# Reset Event Routing Controller

This block receives single-cycle pulses from the sources that can reset the chip: a software request, a core request, a debug-port request, a watchdog and three low-voltage detectors. For each pulse it decides the outcome. An event whose disable bit is clear asks the reset sequencer to run. An event whose disable bit is set does not reset the chip. It raises a safe-mode request pulse or latches an interrupt status bit, and the choice comes from the matching bit of an alternate-routing register.

Three 16-bit registers sit on a simple register bus: the disable mask, the alternate-routing mask and a write-1-to-clear interrupt status. A privilege-mode input governs write access. Each byte of the disable mask can be written once after power-on. Its lock flags survive every reset except power-on. The reset sequencer, the safe-mode logic and the interrupt controller are outside this block and see only the three request lines.

Top module: `rst_route_top`

## Requirements
- R1: An event pulse on an implemented source whose disable bit is 0 gives a one-cycle `resetReq` pulse in the cycle after the event.
- R2: An event on a disabled source whose alternate bit is 0 gives a one-cycle `safeReq` pulse in the cycle after the event, and no `resetReq`.
- R3: An event on a disabled source whose alternate bit is 1 sets that source's bit in the status register (regSel 2) in the cycle after the event. `irqOut` is the OR of the status bits and stays high until a privileged write of 1 to that bit clears it.
- R4: Writes to any register take effect only when privMode is 1 (supervisor) or 2 (test). With privMode 0 (user) or 3, a write changes nothing and does not use up a byte's single write.
- R5: Each byte of the disable register (regSel 0) accepts one privileged write after power-on, selected by byteEn bit 0 for bits 7:0 and byteEn bit 1 for bits 15:8. Later writes to a locked byte have no effect.
- R6: Power-on reset (`porN` low) clears the disable register and both byte locks. Functional reset (`rstN` low) clears the alternate register, the status register and the request outputs, and leaves the disable register and its locks unchanged.
- R7: The implemented sources sit at these bit positions: software 0, core 1, debug port 2, watchdog 8, low-voltage main 9, low-voltage domain A 10, low-voltage domain B 11. All other register bits read 0, and events on those bit positions have no effect.
- R8: When events in one cycle cause both a reset and an alternate request, only `resetReq` is raised, and the status register does not change. Alternate requests from several sources in one cycle combine by OR, so both `safeReq` and new status bits may appear together.
- R9: `rdData` combinationally returns the disable register for regSel 0, the alternate register for regSel 1, the status register for regSel 2 and 0 for regSel 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset, asynchronous, active low |
| rstN | input | 1 | Functional reset, asynchronous, active low |
| evtIn | input | 16 | One-cycle event pulses, one bit per source position |
| wrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 disable, 1 alternate, 2 status |
| byteEn | input | 2 | Byte enables for a write |
| wrData | input | 16 | Write data |
| privMode | input | 2 | Access mode: 0 user, 1 supervisor, 2 test, 3 treated as user |
| rdData | output | 16 | Read data of the selected register |
| resetReq | output | 1 | One-cycle request to start the reset sequence |
| safeReq | output | 1 | One-cycle request to enter safe mode |
| irqOut | output | 1 | Interrupt request, high while any status bit is set |

## Verification
The routing is driven with a lone enabled event, a lone disabled event routed to safe mode, a lone disabled event routed to interrupt, and a pulse on an unassigned bit. These separate the three outcomes from each other and from the case where nothing happens. Two mixed-cycle patterns follow: an enabled event with a disabled one, which shows that the reset suppresses the alternate, and two disabled events with different routes, which shows that both fire together. Register patterns cover a user write before the first privileged write, a second write to a locked byte, a write to the other byte, and a functional reset followed by a power-on reset. Together they tell the lock from the privilege check and one reset domain from the other.

// File: rtl/rst_route_pkg.sv
package rst_route_pkg;
  localparam int REG_W     = 16;
  localparam int BYTE_W    = 8;
  localparam int NUM_BYTES = REG_W / BYTE_W;

  typedef enum logic [1:0] {
    SEL_DIS = 2'd0,
    SEL_ALT = 2'd1,
    SEL_STS = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  typedef enum logic [1:0] {
    MODE_USER = 2'd0,
    MODE_SUPV = 2'd1,
    MODE_TEST = 2'd2,
    MODE_RSVD = 2'd3
  } privMode_e;

  typedef struct packed {
    logic [NUM_BYTES-1:0] disWr;
    logic [NUM_BYTES-1:0] altWr;
    logic [NUM_BYTES-1:0] stsClr;
    regSel_e              rdSel;
  } strobe_t;
endpackage

// File: rtl/rst_route_ctrl.sv
module rst_route_ctrl
  import rst_route_pkg::*;
(
  input  logic                 wrEn,
  input  logic [1:0]           regSel,
  input  logic [NUM_BYTES-1:0] byteEn,
  input  logic [1:0]           privMode,
  output strobe_t              strb
);
  logic    privOk;
  regSel_e sel;
  logic    wrGo;

  always_comb begin
    sel    = regSel_e'(regSel);
    privOk = (privMode_e'(privMode) == MODE_SUPV) || (privMode_e'(privMode) == MODE_TEST);
    wrGo   = wrEn && privOk;
    strb.disWr  = (wrGo && sel == SEL_DIS) ? byteEn : '0;
    strb.altWr  = (wrGo && sel == SEL_ALT) ? byteEn : '0;
    strb.stsClr = (wrGo && sel == SEL_STS) ? byteEn : '0;
    strb.rdSel  = sel;
  end
endmodule

// File: rtl/rst_route_dp.sv
module rst_route_dp
  import rst_route_pkg::*;
#(
  parameter logic [REG_W-1:0] IMPL_MASK = 16'h0F07
)(
  input  logic                 clk,
  input  logic                 porN,
  input  logic                 anyRstN,
  input  logic [REG_W-1:0]     evtIn,
  input  logic [REG_W-1:0]     wrData,
  input  strobe_t              strb,
  output logic [REG_W-1:0]     rdData,
  output logic [REG_W-1:0]     disVal,
  output logic [NUM_BYTES-1:0] lockVal,
  output logic                 resetReq,
  output logic                 safeReq,
  output logic                 irqOut
);
  logic [REG_W-1:0] disQ, altQ, stsQ;
  logic [NUM_BYTES-1:0] lockQ;
  logic [REG_W-1:0] validEvt, altEvt, irqSet, clrMask, stsNext;
  logic rstHit, safeHit;
  logic resetReqQ, safeReqQ;

  // Per-byte disable storage with its write-once lock, plus alternate mask.
  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    localparam int LO = b * BYTE_W;
    always_ff @(posedge clk or negedge porN) begin
      if (!porN) begin
        disQ[LO +: BYTE_W] <= '0;
        lockQ[b]           <= 1'b0;
      end else if (strb.disWr[b] && !lockQ[b]) begin
        disQ[LO +: BYTE_W] <= wrData[LO +: BYTE_W] & IMPL_MASK[LO +: BYTE_W];
        lockQ[b]           <= 1'b1;
      end
    end

    always_ff @(posedge clk or negedge anyRstN) begin
      if (!anyRstN)
        altQ[LO +: BYTE_W] <= '0;
      else if (strb.altWr[b])
        altQ[LO +: BYTE_W] <= wrData[LO +: BYTE_W] & IMPL_MASK[LO +: BYTE_W];
    end

    assign clrMask[LO +: BYTE_W] = strb.stsClr[b] ? wrData[LO +: BYTE_W] : '0;
  end

  // Event routing
  always_comb begin
    validEvt = evtIn & IMPL_MASK;
    rstHit   = |(validEvt & ~disQ);
    altEvt   = validEvt & disQ;
    safeHit  = |(altEvt & ~altQ);
    irqSet   = rstHit ? '0 : (altEvt & altQ);
    stsNext  = ((stsQ & ~clrMask) | irqSet) & IMPL_MASK;
  end

  always_ff @(posedge clk or negedge anyRstN) begin
    if (!anyRstN) begin
      stsQ      <= '0;
      resetReqQ <= 1'b0;
      safeReqQ  <= 1'b0;
    end else begin
      stsQ      <= stsNext;
      resetReqQ <= rstHit;
      safeReqQ  <= safeHit && !rstHit;
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      SEL_DIS: rdData = disQ;
      SEL_ALT: rdData = altQ;
      SEL_STS: rdData = stsQ;
      default: rdData = '0;
    endcase
  end

  assign disVal   = disQ;
  assign lockVal  = lockQ;
  assign resetReq = resetReqQ;
  assign safeReq  = safeReqQ;
  assign irqOut   = |stsQ;
endmodule

// File: rtl/rst_route_top.sv
module rst_route_top
  import rst_route_pkg::*;
#(
  parameter logic [REG_W-1:0] IMPL_MASK = 16'h0F07
)(
  input  logic                 clk,
  input  logic                 porN,
  input  logic                 rstN,
  input  logic [REG_W-1:0]     evtIn,
  input  logic                 wrEn,
  input  logic [1:0]           regSel,
  input  logic [NUM_BYTES-1:0] byteEn,
  input  logic [REG_W-1:0]     wrData,
  input  logic [1:0]           privMode,
  output logic [REG_W-1:0]     rdData,
  output logic                 resetReq,
  output logic                 safeReq,
  output logic                 irqOut
);
  strobe_t              strb;
  logic                 anyRstN;
  logic [REG_W-1:0]     disVal;
  logic [NUM_BYTES-1:0] lockVal;

  assign anyRstN = porN & rstN;

  rst_route_ctrl u_ctrl (
    .wrEn     (wrEn),
    .regSel   (regSel),
    .byteEn   (byteEn),
    .privMode (privMode),
    .strb     (strb)
  );

  rst_route_dp #(.IMPL_MASK(IMPL_MASK)) u_dp (
    .clk      (clk),
    .porN     (porN),
    .anyRstN  (anyRstN),
    .evtIn    (evtIn),
    .wrData   (wrData),
    .strb     (strb),
    .rdData   (rdData),
    .disVal   (disVal),
    .lockVal  (lockVal),
    .resetReq (resetReq),
    .safeReq  (safeReq),
    .irqOut   (irqOut)
  );
endmodule

// File: rtl/rst_route_chk.sv
module rst_route_chk
  import rst_route_pkg::*;
#(
  parameter logic [REG_W-1:0] IMPL_MASK = 16'h0F07
)(
  input logic                 clk,
  input logic                 porN,
  input logic                 rstN,
  input logic [REG_W-1:0]     evtIn,
  input logic                 wrEn,
  input logic [1:0]           privMode,
  input logic [REG_W-1:0]     rdData,
  input logic [REG_W-1:0]     disVal,
  input logic [NUM_BYTES-1:0] lockVal,
  input logic                 resetReq,
  input logic                 safeReq
);
  // R1: enabled event leads to a reset request
  p_enabled_reset_r1: assert property (@(posedge clk) disable iff (!porN || !rstN)
    (|(evtIn & IMPL_MASK & ~disVal)) |=> resetReq);

  // R2: purely disabled events never reset
  p_disabled_no_reset_r2: assert property (@(posedge clk) disable iff (!porN || !rstN)
    ((|(evtIn & IMPL_MASK)) && !(|(evtIn & IMPL_MASK & ~disVal))) |=> !resetReq);

  // R4: unprivileged write leaves the disable register alone
  p_user_no_write_r4: assert property (@(posedge clk) disable iff (!porN)
    (wrEn && (privMode == 2'd0 || privMode == 2'd3)) |=> $stable(disVal));

  // R5: a locked byte never changes
  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lock
    p_lock_hold_r5: assert property (@(posedge clk) disable iff (!porN)
      lockVal[b] |=> $stable(disVal[b*BYTE_W +: BYTE_W]));
  end

  // R7: unassigned bits read as zero
  p_unimpl_zero_r7: assert property (@(posedge clk) disable iff (!porN)
    (rdData & ~IMPL_MASK) == '0);

  // R8: reset and safe-mode requests never coincide
  p_reset_excl_r8: assert property (@(posedge clk) disable iff (!porN || !rstN)
    resetReq |-> !safeReq);
endmodule

bind rst_route_top rst_route_chk #(.IMPL_MASK(IMPL_MASK)) u_chk (
  .clk      (clk),
  .porN     (porN),
  .rstN     (rstN),
  .evtIn    (evtIn),
  .wrEn     (wrEn),
  .privMode (privMode),
  .rdData   (rdData),
  .disVal   (disVal),
  .lockVal  (lockVal),
  .resetReq (resetReq),
  .safeReq  (safeReq)
);

// File: tb/sim_rst_route_top.sv
`timescale 1ns/1ps
module sim_rst_route_top;
  logic        clk = 1'b0;
  logic        porN = 1'b0, rstN = 1'b0;
  logic [15:0] evtIn = '0;
  logic        wrEn = 1'b0;
  logic [1:0]  regSel = '0;
  logic [1:0]  byteEn = '0;
  logic [15:0] wrData = '0;
  logic [1:0]  privMode = '0;
  logic [15:0] rdData;
  logic        resetReq, safeReq, irqOut;
  int checks = 0, errors = 0;

  localparam logic [15:0] SW = 16'h0001, CORE = 16'h0002, DBG = 16'h0004;

  always #5 clk = ~clk;

  rst_route_top u0 (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [1:0] sel, input logic [1:0] be,
                       input logic [15:0] d, input logic [1:0] mode);
    wrEn = 1'b1; regSel = sel; byteEn = be; wrData = d; privMode = mode;
    @(negedge clk);
    wrEn = 1'b0; byteEn = '0; wrData = '0;
  endtask

  task automatic rdChk(input string req, input logic [1:0] sel, input logic [15:0] exp);
    regSel = sel; #1;
    chk(req, rdData, exp);
  endtask

  // Drive a pulse, return outputs in the following cycle.
  task automatic pulse(input logic [15:0] ev, output logic [2:0] outs);
    evtIn = ev;
    @(negedge clk);
    evtIn = '0;
    outs = {resetReq, safeReq, irqOut};
  endtask

  task automatic t_reset_state();
    rdChk("R6 disable after POR", 2'd0, 16'h0000);
    rdChk("R6 alt after POR", 2'd1, 16'h0000);
    rdChk("R6 status after POR", 2'd2, 16'h0000);
    chk("R6 outputs after POR", {13'd0, resetReq, safeReq, irqOut}, 16'h0000);
  endtask

  task automatic t_enabled();
    logic [2:0] o;
    pulse(SW, o);
    chk("R1 sw reset pulse", {13'd0, o}, 16'h0004);
    @(negedge clk);
    chk("R1 reset is one cycle", {15'd0, resetReq}, 16'h0000);
    pulse(16'h0800, o);
    chk("R1 low-voltage B reset", {13'd0, o}, 16'h0004);
    @(negedge clk);
  endtask

  task automatic t_access();
    busWr(2'd0, 2'b01, 16'h0007, 2'd0);
    rdChk("R4 user write ignored", 2'd0, 16'h0000);
    busWr(2'd0, 2'b01, 16'h0007, 2'd3);
    rdChk("R4 mode 3 write ignored", 2'd0, 16'h0000);
    busWr(2'd0, 2'b01, 16'h0005, 2'd1);
    rdChk("R4 supervisor write after user tries", 2'd0, 16'h0005);
    busWr(2'd0, 2'b01, 16'h0007, 2'd1);
    rdChk("R5 low byte locked", 2'd0, 16'h0005);
    busWr(2'd0, 2'b10, 16'hFFFF, 2'd2);
    rdChk("R7 test write high byte masked", 2'd0, 16'h0F05);
    busWr(2'd0, 2'b10, 16'h0000, 2'd2);
    rdChk("R5 high byte locked", 2'd0, 16'h0F05);
    rdChk("R9 select 3 reads zero", 2'd3, 16'h0000);
  endtask

  task automatic t_alternate();
    logic [2:0] o;
    busWr(2'd1, 2'b11, 16'hFFFF, 2'd0);
    rdChk("R4 user alt write ignored", 2'd1, 16'h0000);
    busWr(2'd1, 2'b11, 16'h0804, 2'd1);
    rdChk("R9 alt readback", 2'd1, 16'h0804);
    pulse(SW, o);
    chk("R2 sw safe pulse", {13'd0, o}, 16'h0002);
    @(negedge clk);
    chk("R2 safe is one cycle", {15'd0, safeReq}, 16'h0000);
    pulse(DBG, o);
    chk("R3 debug irq", {13'd0, o}, 16'h0001);
    rdChk("R3 status bit", 2'd2, 16'h0004);
    repeat (3) @(negedge clk);
    chk("R3 irq held", {15'd0, irqOut}, 16'h0001);
    busWr(2'd2, 2'b11, 16'hFFFF, 2'd0);
    chk("R4 user clear ignored", {15'd0, irqOut}, 16'h0001);
    busWr(2'd2, 2'b01, 16'h0004, 2'd1);
    chk("R3 clear drops irq", {15'd0, irqOut}, 16'h0000);
    pulse(CORE, o);
    chk("R1 core still enabled", {13'd0, o}, 16'h0004);
    @(negedge clk);
  endtask

  task automatic t_mixed();
    logic [2:0] o;
    pulse(SW | CORE | 16'h0800, o);
    chk("R8 reset wins", {13'd0, o}, 16'h0004);
    rdChk("R8 status untouched", 2'd2, 16'h0000);
    @(negedge clk);
    pulse(SW | DBG, o);
    chk("R8 alternates combine", {13'd0, o}, 16'h0003);
    rdChk("R8 status bit from mix", 2'd2, 16'h0004);
    busWr(2'd2, 2'b11, 16'hFFFF, 2'd2);
    pulse(16'h0020, o);
    chk("R7 unassigned event ignored", {13'd0, o}, 16'h0000);
  endtask

  task automatic t_resets();
    logic [2:0] o;
    pulse(DBG, o);
    rstN = 1'b0; @(negedge clk); rstN = 1'b1; #1;
    rdChk("R6 functional reset keeps disable", 2'd0, 16'h0F05);
    rdChk("R6 functional reset clears alt", 2'd1, 16'h0000);
    rdChk("R6 functional reset clears status", 2'd2, 16'h0000);
    busWr(2'd0, 2'b11, 16'h0000, 2'd1);
    rdChk("R6 locks survive functional reset", 2'd0, 16'h0F05);
    porN = 1'b0; @(negedge clk); porN = 1'b1; #1;
    rdChk("R6 POR clears disable", 2'd0, 16'h0000);
    busWr(2'd0, 2'b11, 16'h0102, 2'd1);
    rdChk("R6 POR clears locks", 2'd0, 16'h0102);
    pulse(CORE, o);
    chk("R2 core now safe-mode", {13'd0, o}, 16'h0002);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    porN = 1'b1; rstN = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_enabled();
    t_access();
    t_alternate();
    t_mixed();
    t_resets();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule